// File: doc/BRIEF.md
# VLIW Execute Packet Splitter

This block sits between instruction fetch and decode in a very-long-instruction-word core. Fetch hands it one 256-bit fetch packet at a time, made of eight 32-bit instruction words. The block splits that packet into execute packets, which are the groups of words that issue together in one cycle. It emits one execute packet per accepted cycle as a slot mask alongside the full packet word, so decode can pick out the selected slots.

Group membership is carried inside the instructions themselves. Bit 0 of each word is a chaining flag that ties the word to the slot after it. A group can never run past the last slot of its fetch packet, so a single fetch packet may take anywhere from one to eight issue cycles. While the block works through a packet, fetch is held off. Fetch sees ready only in the cycle that issues the group holding the final slot.

The block carries no instruction words of its own. It keeps only a slot pointer and relies on the upstream valid/ready protocol to hold the fetch packet steady until that packet has been consumed. Opcode decoding, unit routing and predication are left to later stages.

Top module: `vliw_issue_splitter`

## Requirements
- R1: Slot i occupies bits [32*i+31 : 32*i] of the fetch packet. Slots are scanned upward from slot 0, and every fetch packet's first execute packet starts at slot 0.
- R2: When ep_valid is high, ep_mask bit i is set exactly when slot i belongs to the current execute packet. The set bits form one contiguous run that starts at the slot just after the previous execute packet of the same fetch packet.
- R3: A slot whose bit 0 is 1 pulls the next slot into its execute packet, for every slot except the last.
- R4: A slot whose bit 0 is 0 is the final slot of its execute packet.
- R5: Slot 7 always closes the execute packet, whatever its bit 0 holds. No execute packet spans two fetch packets.
- R6: When bit 0 is 1 in slots 0 to 6, the whole fetch packet issues in one cycle with ep_mask = 8'hFF.
- R7: fp_ready is high only in a cycle with ep_valid and ep_ready both high and ep_mask bit 7 set.
- R8: While ep_valid is high and ep_ready is low, ep_mask and ep_data stay unchanged in the next cycle and the slot pointer does not advance.
- R9: ep_data equals fp_data bit for bit. All-zero (NOP) words are issued in their slots like any other word and are never skipped.
- R10: Synchronous active-high reset returns the slot pointer to 0. ep_valid is low while rst is high.
- R11: While fp_valid is low, ep_valid is low and the slot pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fp_valid | input | 1 | Fetch packet present |
| fp_data | input | 256 | Fetch packet, slot 0 in the low word |
| fp_ready | output | 1 | Fetch packet fully consumed this cycle |
| ep_valid | output | 1 | Execute packet present |
| ep_mask | output | 8 | Slots in the current execute packet |
| ep_data | output | 256 | Fetch packet word carried to decode |
| ep_ready | input | 1 | Decode accepts the execute packet |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:
- Chaining flag clear in every slot: a splitter that merges neighbouring slots would issue fewer than eight groups.
- Chaining flag set in every slot, including slot 7: a design that does not force a close at slot 7 would chain into a slot that does not exist and never release fetch.
- Flags 0 to 6 set with slot 7 clear: this has to issue as a single 8'hFF group. A wrong count would show up as an extra cycle.
- Back-pressure, a dropped fetch valid, and a reset in the middle of a packet: these expose a pointer that advances when it should hold or that fails to return to slot 0.

// File: rtl/vis_pkg.sv
package vis_pkg;

    // Default geometry of a fetch packet
    localparam int unsigned DEF_SLOTS     = 8;
    localparam int unsigned DEF_WORD_W    = 32;
    // Position of the chaining flag inside each instruction word
    localparam int unsigned DEF_CHAIN_BIT = 0;

endpackage

// File: rtl/vis_span.sv
// Builds the slot mask of one execute packet from the start slot and the
// chaining flags of every slot but the last (the last one always closes).
module vis_span #(
    parameter int unsigned SLOTS = vis_pkg::DEF_SLOTS,
    localparam int unsigned PTR_W = $clog2(SLOTS)
) (
    input  logic [PTR_W-1:0] start,
    input  logic [SLOTS-2:0] chain,
    output logic [SLOTS-1:0] mask
);

    logic [SLOTS-1:0] sel;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i == 0) begin : g_first
            assign sel[i] = (start == '0);
        end else begin : g_rest
            // slot i is in the group if it is the start, or its lower
            // neighbour is in the group and chains forward
            assign sel[i] = (start == PTR_W'(i)) || (sel[i-1] && chain[i-1]);
        end
    end

    assign mask = sel;

endmodule

// File: rtl/vis_advance.sv
// Computes the slot pointer that follows an issued execute packet.
module vis_advance #(
    parameter int unsigned SLOTS = vis_pkg::DEF_SLOTS,
    localparam int unsigned PTR_W = $clog2(SLOTS)
) (
    input  logic [PTR_W-1:0] cur_ptr,
    input  logic [SLOTS-1:0] mask,
    output logic [PTR_W-1:0] next_ptr
);

    logic [PTR_W:0] cnt;
    logic [PTR_W:0] sum;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < SLOTS; i++) begin
            cnt = cnt + (PTR_W+1)'(mask[i]);
        end
        sum = {1'b0, cur_ptr} + cnt;
        // a carry out means the group reached the last slot
        next_ptr = sum[PTR_W] ? '0 : sum[PTR_W-1:0];
    end

endmodule

// File: rtl/vliw_issue_splitter.sv
module vliw_issue_splitter #(
    parameter int unsigned SLOTS     = vis_pkg::DEF_SLOTS,
    parameter int unsigned WORD_W    = vis_pkg::DEF_WORD_W,
    parameter int unsigned CHAIN_BIT = vis_pkg::DEF_CHAIN_BIT,
    localparam int unsigned PKT_W    = SLOTS * WORD_W,
    localparam int unsigned PTR_W    = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fp_valid,
    input  logic [PKT_W-1:0] fp_data,
    output logic             fp_ready,
    output logic             ep_valid,
    output logic [SLOTS-1:0] ep_mask,
    output logic [PKT_W-1:0] ep_data,
    input  logic             ep_ready
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } state_t;

    state_t           st_q, st_d;
    logic [SLOTS-2:0] chain;
    logic [PTR_W-1:0] ptr_adv;
    logic             fire;

    // Chaining flags; the last slot's flag is never consulted
    for (genvar s = 0; s < SLOTS - 1; s++) begin : g_chain
        assign chain[s] = fp_data[s*WORD_W + CHAIN_BIT];
    end

    vis_span #(.SLOTS(SLOTS)) u_span (
        .start (st_q.ptr),
        .chain (chain),
        .mask  (ep_mask)
    );

    vis_advance #(.SLOTS(SLOTS)) u_adv (
        .cur_ptr  (st_q.ptr),
        .mask     (ep_mask),
        .next_ptr (ptr_adv)
    );

    always_comb begin
        ep_valid = fp_valid && !rst;
        ep_data  = fp_data;
        fire     = ep_valid && ep_ready;
        fp_ready = fire && ep_mask[SLOTS-1];
        st_d     = st_q;
        if (fire) begin
            st_d.ptr = ptr_adv;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Group membership agrees with the chaining flags of the slots
    for (genvar a = 0; a < SLOTS - 1; a++) begin : g_chk
        assert_join_R3: assert property (@(posedge clk) disable iff (rst)
            (ep_valid && ep_mask[a] && ep_mask[a+1]) |-> chain[a]);
        assert_split_R4: assert property (@(posedge clk) disable iff (rst)
            (ep_valid && ep_mask[a] && !ep_mask[a+1]) |-> !chain[a]);
    end

    // After the last slot issues, the next group starts at slot 0
    assert_restart_R1: assert property (@(posedge clk) disable iff (rst)
        (fire && ep_mask[SLOTS-1]) |=> (!ep_valid || ep_mask[0]));

    // The next group begins right above the previous group's top slot
    assert_contig_R2: assert property (@(posedge clk) disable iff (rst)
        (fire && !ep_mask[SLOTS-1]) |=>
        (!ep_valid || ((ep_mask & (~ep_mask + SLOTS'(1))) ==
            (($past(ep_mask) & ~($past(ep_mask) >> 1)) << 1))));

    // Back-pressure freezes the offered group
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (ep_valid && !ep_ready) |=>
        (!ep_valid || ($stable(ep_mask) && $stable(ep_data))));

    // Reset sends the pointer back to the first slot
    assert_reset_R10: assert property (@(posedge clk)
        rst |=> (!ep_valid || ep_mask[0]));

endmodule

// File: tb/sim_vliw_issue_splitter.sv
module sim_vliw_issue_splitter;

    logic         clk = 1'b0;
    logic         rst;
    logic         fp_valid;
    logic [255:0] fp_data;
    logic         fp_ready;
    logic         ep_valid;
    logic [7:0]   ep_mask;
    logic [255:0] ep_data;
    logic         ep_ready;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    vliw_issue_splitter u0 (
        .clk      (clk),
        .rst      (rst),
        .fp_valid (fp_valid),
        .fp_data  (fp_data),
        .fp_ready (fp_ready),
        .ep_valid (ep_valid),
        .ep_mask  (ep_mask),
        .ep_data  (ep_data),
        .ep_ready (ep_ready)
    );

    typedef struct packed {
        logic [7:0]  pb;   // chaining flag of slot i in bit i
        logic [3:0]  n;    // number of execute packets
        logic [63:0] m;    // mask k in bits [8k+7:8k]
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h00, 4'd8, 64'h8040_2010_0804_0201},  // R4: all flags clear
        '{8'hFF, 4'd1, 64'h0000_0000_0000_00FF},  // R5, R6: all flags set
        '{8'h7F, 4'd1, 64'h0000_0000_0000_00FF},  // R6: slots 0..6 chain
        '{8'h80, 4'd8, 64'h8040_2010_0804_0201},  // R5: flag only on slot 7
        '{8'h03, 4'd6, 64'h0000_8040_2010_0807},  // R3: slots 0,1 chain
        '{8'hAA, 4'd5, 64'h0000_0080_6018_0601},  // R1, R2: odd slots chain
        '{8'h55, 4'd4, 64'h0000_0000_C030_0C03},  // R3, R4: even slots chain
        '{8'h3C, 4'd4, 64'h0000_0000_807C_0201}   // R2: long middle group
    };

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [255:0] make_pkt(input logic [7:0] pb, input int seed);
        logic [255:0] d;
        for (int s = 0; s < 8; s++) begin
            logic [31:0] w;
            w = 32'(seed) * 32'h9E37_79B1 + 32'(s) * 32'h0101_0107;
            if ((seed % 3) == 0 && s == 2) w = 32'h0;   // NOP word
            w[0] = pb[s];
            d[s*32 +: 32] = w;
        end
        return d;
    endfunction

    // Reference model written from R1..R6
    task automatic ref_model(input logic [7:0] pb, output int n, output logic [63:0] m);
        int st;
        n = 0;
        m = '0;
        st = 0;
        while (st < 8) begin
            int en;
            logic [7:0] mk;
            en = st;
            while (en < 7 && pb[en]) en++;
            mk = '0;
            for (int i = st; i <= en; i++) mk[i] = 1'b1;
            m[n*8 +: 8] = mk;
            n++;
            st = en + 1;
        end
    endtask

    task automatic run_packet(input logic [255:0] d, input int n,
                              input logic [63:0] m, input bit stall);
        @(negedge clk);
        fp_valid = 1'b1;
        fp_data  = d;
        for (int k = 0; k < n; k++) begin
            if (stall && $urandom_range(0, 2) == 0) begin
                ep_ready = 1'b0;
                #5;
                chk("R8", "mask under stall", 256'(ep_mask), 256'(m[k*8 +: 8]));
                chk("R7", "ready under stall", 256'(fp_ready), 256'(0));
                @(negedge clk);
            end
            ep_ready = 1'b1;
            #5;
            chk("R2", "valid", 256'(ep_valid), 256'(1));
            chk("R2", "mask", 256'(ep_mask), 256'(m[k*8 +: 8]));
            chk("R7", "fetch ready", 256'(fp_ready), 256'(k == n - 1));
            chk("R9", "data", ep_data, d);
            @(negedge clk);
        end
        fp_valid = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL R7 watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        fp_valid = 1'b1;
        fp_data  = make_pkt(8'h00, 5);
        ep_ready = 1'b1;
        @(negedge clk);
        #5;
        chk("R10", "valid in reset", 256'(ep_valid), 256'(0));
        chk("R10", "ready in reset", 256'(fp_ready), 256'(0));
        @(negedge clk);
        fp_valid = 1'b0;
        rst      = 1'b0;
        #5;
        chk("R11", "valid without fetch", 256'(ep_valid), 256'(0));

        // table walk
        for (int v = 0; v < 8; v++) begin
            run_packet(make_pkt(VECS[v].pb, v + 1), int'(VECS[v].n), VECS[v].m, 1'b0);
        end

        // R8: back-pressure on a one-slot-per-group packet
        run_packet(make_pkt(8'h00, 21), 8, 64'h8040_2010_0804_0201, 1'b1);

        // R11: fetch valid dropped mid-packet, pointer must hold
        @(negedge clk);
        fp_valid = 1'b1;
        fp_data  = make_pkt(8'h00, 30);
        ep_ready = 1'b1;
        #5 chk("R11", "first group", 256'(ep_mask), 256'(8'h01));
        @(negedge clk);
        #5 chk("R11", "second group", 256'(ep_mask), 256'(8'h02));
        @(negedge clk);
        fp_valid = 1'b0;
        #5 chk("R11", "valid dropped", 256'(ep_valid), 256'(0));
        @(negedge clk);
        @(negedge clk);
        fp_valid = 1'b1;
        #5 chk("R11", "resumed group", 256'(ep_mask), 256'(8'h04));

        // R10: reset in the middle of a packet
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #5 chk("R10", "restart at slot 0", 256'(ep_mask), 256'(8'h01));
        @(negedge clk);
        for (int k = 1; k < 8; k++) @(negedge clk);
        fp_valid = 1'b0;

        // random packets against the reference model
        for (int r = 0; r < 40; r++) begin
            logic [7:0]  pb;
            int          n;
            logic [63:0] m;
            pb = 8'($urandom);
            ref_model(pb, n, m);
            run_packet(make_pkt(pb, 100 + r), n, m, 1'b1);
        end

        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule